// File: doc/BRIEF.md
# Carry-Select Absolute Difference Unit

This block forms one term of a sum-of-absolute-differences reduction. Each cycle it may take two unsigned pel values and produce a term that is exactly one less than their absolute difference, modulo 2^W. It never performs a signed subtraction. A network made only of carry-generate and carry-propagate logic finds out which operand is larger. No sum bits come out of that network. The larger operand is then added to the bit-inverted smaller one.

The missing +1 of the two's-complement subtraction is deliberately left out. A downstream summation stage adds one for every term as a single constant count. For equal operands the term is all ones, so term+1 wraps to zero. An equality flag also lets the summer drop such a term.

The datapath is W bits wide everywhere, with no sign extension. Results are registered one cycle after a valid input, and the output holds while no input is valid.

Top module: `absd_unit`

## Requirements
- R1: After a synchronous active-high reset, `out_valid` is 0, `term_o` is 0 and `equal_o` is 0.
- R2: `out_valid` is high exactly in the cycle after a cycle in which `in_valid` was high, and low otherwise.
- R3: For a valid input with A > B, the next `term_o` equals A + (~B) truncated to W bits, which is A − B − 1, so (term_o + 1) mod 2^W = A − B.
- R4: For a valid input with B > A, the next `term_o` equals B + (~A) truncated to W bits, which is B − A − 1, so (term_o + 1) mod 2^W = B − A.
- R5: For a valid input with A = B, the next `term_o` is all ones (8'hFF for W = 8) and `equal_o` is 1. For any valid input with A ≠ B, `equal_o` is 0.
- R6: In a cycle with `in_valid` low, the input values have no effect: in the next cycle `term_o` and `equal_o` keep their previous values.
- R7: The extreme operand pairs (0, 2^W−1) and (2^W−1, 0) both give a `term_o` of 2^W−2 (8'hFE for W = 8).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Qualifies `a_i` and `b_i` this cycle |
| a_i | input | W (8) | Unsigned operand A |
| b_i | input | W (8) | Unsigned operand B |
| out_valid | output | 1 | `term_o` and `equal_o` hold a new result |
| term_o | output | W (8) | Absolute difference minus one, modulo 2^W |
| equal_o | output | 1 | The operands of the latest result were equal |

## Verification
Every result is due exactly one clock edge after its input is presented. The bench drives each input pair on a falling edge. It then compares all three outputs on the following falling edge against a model updated at the time of driving, so each check lands one register stage after its stimulus. Every (A, B) pair is swept, and bubble cycles are mixed in with changing operand values. Each bubble lets the next comparison confirm that the term and the equality flag held their values.

// File: rtl/absd_pkg.sv
package absd_pkg;
  localparam int unsigned PEL_W = 8;

  // Order decision handed from the carry network to the steering logic.
  typedef struct packed {
    logic a_ge_b;
    logic equal;
  } absd_order_t;
endpackage

// File: rtl/absd_carry_gen.sv
module absd_carry_gen #(
  parameter int unsigned W = absd_pkg::PEL_W
) (
  input  logic                 [W-1:0] a_i,
  input  logic                 [W-1:0] b_i,
  output absd_pkg::absd_order_t        order_o
);
  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   carry;

  // Carry-in of one models the hot one. Only the carries are built, no sum bits.
  assign carry[0] = 1'b1;

  for (genvar i = 0; i < W; i++) begin : g_chain
    assign gen[i]     = a_i[i] & ~b_i[i];
    assign prop[i]    = a_i[i] ~^ b_i[i];
    assign carry[i+1] = gen[i] | (prop[i] & carry[i]);
  end

  assign order_o.a_ge_b = carry[W];
  assign order_o.equal  = &prop;
endmodule

// File: rtl/absd_steer.sv
module absd_steer #(
  parameter int unsigned W = absd_pkg::PEL_W
) (
  input  logic                 [W-1:0] a_i,
  input  logic                 [W-1:0] b_i,
  input  absd_pkg::absd_order_t        order_i,
  output logic                 [W-1:0] big_o,
  output logic                 [W-1:0] small_inv_o
);
  always_comb begin
    if (order_i.a_ge_b) begin
      big_o       = a_i;
      small_inv_o = ~b_i;
    end else begin
      big_o       = b_i;
      small_inv_o = ~a_i;
    end
  end
endmodule

// File: rtl/absd_term_add.sv
module absd_term_add #(
  parameter int unsigned W = absd_pkg::PEL_W
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  output logic [W-1:0] sum_o
);
  // The carry-out is dropped. The +1 is added later, once per term, by the summer.
  assign sum_o = x_i + y_i;
endmodule

// File: rtl/absd_unit.sv
module absd_unit #(
  parameter int unsigned W = absd_pkg::PEL_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         out_valid,
  output logic [W-1:0] term_o,
  output logic         equal_o
);
  absd_pkg::absd_order_t order;
  logic [W-1:0] big;
  logic [W-1:0] small_inv;
  logic [W-1:0] term_next;

  absd_carry_gen #(.W(W)) u_carry (
    .a_i(a_i), .b_i(b_i), .order_o(order)
  );

  absd_steer #(.W(W)) u_steer (
    .a_i(a_i), .b_i(b_i), .order_i(order),
    .big_o(big), .small_inv_o(small_inv)
  );

  absd_term_add #(.W(W)) u_add (
    .x_i(big), .y_i(small_inv), .sum_o(term_next)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      term_o    <= '0;
      equal_o   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        term_o  <= term_next;
        equal_o <= order.equal;
      end
    end
  end

  // Set once at least one non-reset edge has passed, so $past is meaningful.
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (rst)
    armed |-> (out_valid == $past(in_valid)));

  // R3 and R4: term plus one equals the absolute difference of the captured operands.
  a_r3_term_plus_one: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(in_valid)) |->
      (W'(term_o + W'(1)) == (($past(a_i) >= $past(b_i)) ?
                              W'($past(a_i) - $past(b_i)) :
                              W'($past(b_i) - $past(a_i)))));

  a_r5_equal_all_ones: assert property (@(posedge clk) disable iff (rst)
    equal_o |-> (term_o == '1));

  a_r6_hold_on_bubble: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(in_valid)) |-> ($stable(term_o) && $stable(equal_o)));
endmodule

// File: tb/absd_unit_tb.sv
module absd_unit_tb;
  localparam int W = 8;
  localparam int MAXV = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rst;
  logic         in_valid;
  logic [W-1:0] a_i;
  logic [W-1:0] b_i;
  logic         out_valid;
  logic [W-1:0] term_o;
  logic         equal_o;

  always #5 clk = ~clk;

  absd_unit #(.W(W)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .a_i(a_i), .b_i(b_i),
    .out_valid(out_valid), .term_o(term_o), .equal_o(equal_o)
  );

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 1'b0;
  logic         exp_valid;
  logic [W-1:0] exp_term;
  logic         exp_eq;
  string        exp_tag;

  task automatic check_outputs();
    n_checks++;
    if (out_valid !== exp_valid || term_o !== exp_term || equal_o !== exp_eq) begin
      n_fails++;
      $display("FAIL %s: got valid=%0b term=%02h eq=%0b, expected valid=%0b term=%02h eq=%0b",
               exp_tag, out_valid, term_o, equal_o, exp_valid, exp_term, exp_eq);
    end
  endtask

  // Called on a falling edge: check the result due now, then drive the next input.
  task automatic step(input bit v, input int a, input int b);
    int d;
    check_outputs();
    in_valid = v;
    a_i      = W'(a);
    b_i      = W'(b);
    if (v) begin
      d         = (a >= b) ? a - b : b - a;
      exp_valid = 1'b1;
      exp_term  = W'((d - 1) & MAXV);
      exp_eq    = (a == b);
      if (a == b)                                        exp_tag = "R5";
      else if ((a == 0 && b == MAXV) || (a == MAXV && b == 0)) exp_tag = "R7";
      else if (a > b)                                    exp_tag = "R3";
      else                                               exp_tag = "R4";
      exp_tag = {exp_tag, "/R2"};
    end else begin
      exp_valid = 1'b0;
      exp_tag   = "R6/R2";
    end
    @(negedge clk);
  endtask

  initial begin
    int bubble;
    rst = 1'b1; in_valid = 1'b1; a_i = 8'h12; b_i = 8'h34;
    repeat (3) @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    exp_valid = 1'b0; exp_term = '0; exp_eq = 1'b0; exp_tag = "R1";
    check_outputs();                 // R1: reset state
    rst = 1'b0;
    @(negedge clk);
    exp_tag = "R1";
    bubble = 0;
    for (int ia = 0; ia <= MAXV; ia++) begin
      for (int ib = 0; ib <= MAXV; ib++) begin
        step(1'b1, ia, ib);
        bubble++;
        if (bubble % 97 == 0) step(1'b0, (ia * 7 + 3) & MAXV, (ib * 5 + 1) & MAXV); // R6
      end
    end
    step(1'b1, 0, MAXV);             // R7
    step(1'b1, MAXV, 0);             // R7
    step(1'b1, 77, 77);              // R5 true zero case
    step(1'b0, 200, 3);              // R6: hold after equality
    step(1'b0, 0, 0);
    check_outputs();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: got no completion, expected completion within 200000 cycles");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  end
endmodule